// File: doc/BRIEF.md
# Channel Status Flag Output Unit

This block sits behind a bi-phase audio receiver's decoder. It turns decoded channel-status information and the receiver's health signals into two status pins and a gated serial data stream. The non-audio pin reports whether the incoming stream carries linear PCM or non-audio data. It can also fold in externally supplied compressed-stream detection flags.

A second, multiplexed status pin reports either the consumer pre-emphasis setting or an unlock indication. A receive error drives both pins high in the same cycle. Channel-status values are captured once per block, at the block-start preamble, so the pins stay steady within a block.

Serial sample output stays off until several conditions hold. The PLL must report lock, and all three preamble kinds must have been seen while locked. The receive error must be low. Output then starts at the next LR clock transition and stops again on any error or loss of lock.

Top module: `chst_flag_unit`

## Requirements
- R1: After reset the non-audio pin, the status pin (with the status select high), the data enable and the serial data output are all 0.
- R2: With no error and the OR select low, the non-audio pin shows the latched channel-status bit 1: 0 for PCM audio, 1 for non-audio data.
- R3: Channel-status inputs are captured only on a preamble strobe of kind code 0 (block start). Changing them at any other time leaves both pins unchanged.
- R4: With the OR select high, the non-audio pin is the OR of the latched bit 1 and every detection flag. With the OR select low, the flags have no effect.
- R5: With the status select high, the status pin shows the latched emphasis bit: 0 for none, 1 for 50/15 us pre-emphasis.
- R6: With the status select low, the status pin shows the inverse of the lock input.
- R7: While the receive error is high, both pins are 1 in the same cycle, without waiting for a clock edge.
- R8: Data output is enabled only after preamble kinds 0, 1 and 2 have each been strobed while locked. Kind code 3 counts as none of them, and loss of lock erases the record.
- R9: Once armed, the data enable rises on the second rising clock edge after an LR clock transition, and not before.
- R10: A receive error or loss of lock clears the data enable at the next clock edge. Re-enabling needs a fresh LR clock transition after the cause has gone.
- R11: The serial data output equals the serial data input while enabled, and is 0 otherwise.
- R12: A block-start strobe that arrives while the receive error is high does not update the latched channel status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_err | input | 1 | Receive error from the decoder |
| pll_lock | input | 1 | PLL lock indication |
| pre_stb | input | 1 | Preamble detected strobe |
| pre_kind | input | 2 | Preamble kind: 0 block start, 1 and 2 subframe kinds, 3 none |
| cs_nonaudio | input | 1 | Decoded channel-status bit 1 |
| cs_emph | input | 1 | Decoded pre-emphasis flag |
| cmp_flags | input | NUM_FLAGS | Compressed-stream detection flags |
| or_sel | input | 1 | OR detection flags into the non-audio pin |
| stat_sel | input | 1 | Status pin source: 1 emphasis, 0 unlock |
| lrck | input | 1 | LR (word) clock from the formatter |
| sdata_in | input | 1 | Demodulated serial data |
| nonaudio_o | output | 1 | Non-audio indicator pin |
| stat_o | output | 1 | Multiplexed status pin |
| data_en_o | output | 1 | Serial output enable |
| sdata_o | output | 1 | Gated serial data |

## Verification
The non-audio pin is driven through four cases. It sees channel-status values held back from the block-start strobe and then captured by it, detection flags with each OR setting, and an error pulse that arrives together with a block-start strobe. Together these separate capture timing, the flag merge and the immediate error override.

The enable path is tested with incomplete preamble sets, including the unused kind code. The LR transition is sampled one and two edges after it occurs, which pins down the synchronizer latency. Drops are provoked by both error and lock loss, and a re-enable attempt without a new LR transition shows whether the restart condition is honoured.

// File: rtl/chst_pkg.sv
package chst_pkg;
    typedef enum logic [1:0] {
        PRE_BLK  = 2'd0,
        PRE_SUBA = 2'd1,
        PRE_SUBB = 2'd2,
        PRE_NONE = 2'd3
    } pre_kind_e;

    localparam int NUM_KINDS = 3;

    typedef struct packed {
        logic nonaudio;
        logic emph;
    } cs_state_t;
endpackage

// File: rtl/chst_latch.sv
module chst_latch
    import chst_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pre_stb,
    input  logic [1:0] pre_kind,
    input  logic      rx_err,
    input  logic      cs_nonaudio,
    input  logic      cs_emph,
    output cs_state_t cs_q_o
);
    cs_state_t cs_d, cs_q;
    logic      blk_start;

    always_comb begin
        blk_start = pre_stb && (pre_kind == PRE_BLK) && !rx_err;
        cs_d = cs_q;
        if (blk_start) begin
            cs_d.nonaudio = cs_nonaudio;
            cs_d.emph     = cs_emph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign cs_q_o = cs_q;

    AST_HOLD_OFF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_stb && pre_kind == PRE_BLK) |=> $stable(cs_q)); // R3
    AST_ERR_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> $stable(cs_q)); // R12
endmodule

// File: rtl/chst_gate.sv
module chst_gate
    import chst_pkg::*;
#(
    parameter int LR_SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pre_stb,
    input  logic [1:0] pre_kind,
    input  logic       pll_lock,
    input  logic       rx_err,
    input  logic       lrck,
    output logic       data_en_o
);
    typedef struct packed {
        logic [NUM_KINDS-1:0] seen;
        logic [LR_SYNC-1:0]   lr_sync;
        logic                 data_en;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        lr_edge;
    logic        armed;
    logic        drop;

    always_comb begin
        st_d    = st_q;
        lr_edge = st_q.lr_sync[LR_SYNC-1] ^ st_q.lr_sync[LR_SYNC-2];
        drop    = rx_err || !pll_lock;
        armed   = (&st_q.seen) && pll_lock && !rx_err;

        st_d.lr_sync = {st_q.lr_sync[LR_SYNC-2:0], lrck};

        if (!pll_lock) begin
            st_d.seen = '0;
        end else if (pre_stb) begin
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (pre_kind == 2'(k)) st_d.seen[k] = 1'b1;
            end
        end

        if (drop)                  st_d.data_en = 1'b0;
        else if (armed && lr_edge) st_d.data_en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_en_o = st_q.data_en;

    AST_EN_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.data_en && !(armed && lr_edge)) |=> !st_q.data_en); // R9
    AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err || !pll_lock) |=> !st_q.data_en); // R10
    AST_EN_ALL_KINDS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.data_en |-> (&st_q.seen)); // R8
    AST_UNLOCK_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_lock |=> (st_q.seen == '0)); // R8
endmodule

// File: rtl/chst_pins.sv
module chst_pins
    import chst_pkg::*;
#(
    parameter int NUM_FLAGS = 2
) (
    input  cs_state_t            cs_q,
    input  logic [NUM_FLAGS-1:0] cmp_flags,
    input  logic                 or_sel,
    input  logic                 stat_sel,
    input  logic                 pll_lock,
    input  logic                 rx_err,
    output logic                 nonaudio_o,
    output logic                 stat_o
);
    logic any_flag;
    logic na_base;
    logic stat_base;

    always_comb begin
        any_flag   = |cmp_flags;
        na_base    = cs_q.nonaudio | (or_sel & any_flag);
        stat_base  = stat_sel ? cs_q.emph : !pll_lock;
        nonaudio_o = rx_err | na_base;
        stat_o     = rx_err | stat_base;
    end
endmodule

// File: rtl/chst_flag_unit.sv
module chst_flag_unit
    import chst_pkg::*;
#(
    parameter int NUM_FLAGS = 2,
    parameter int LR_SYNC   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_err,
    input  logic                 pll_lock,
    input  logic                 pre_stb,
    input  logic [1:0]           pre_kind,
    input  logic                 cs_nonaudio,
    input  logic                 cs_emph,
    input  logic [NUM_FLAGS-1:0] cmp_flags,
    input  logic                 or_sel,
    input  logic                 stat_sel,
    input  logic                 lrck,
    input  logic                 sdata_in,
    output logic                 nonaudio_o,
    output logic                 stat_o,
    output logic                 data_en_o,
    output logic                 sdata_o
);
    cs_state_t cs_q;
    logic      en;

    chst_latch i_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_stb     (pre_stb),
        .pre_kind    (pre_kind),
        .rx_err      (rx_err),
        .cs_nonaudio (cs_nonaudio),
        .cs_emph     (cs_emph),
        .cs_q_o      (cs_q)
    );

    chst_gate #(.LR_SYNC(LR_SYNC)) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_stb   (pre_stb),
        .pre_kind  (pre_kind),
        .pll_lock  (pll_lock),
        .rx_err    (rx_err),
        .lrck      (lrck),
        .data_en_o (en)
    );

    chst_pins #(.NUM_FLAGS(NUM_FLAGS)) i_pins (
        .cs_q       (cs_q),
        .cmp_flags  (cmp_flags),
        .or_sel     (or_sel),
        .stat_sel   (stat_sel),
        .pll_lock   (pll_lock),
        .rx_err     (rx_err),
        .nonaudio_o (nonaudio_o),
        .stat_o     (stat_o)
    );

    assign data_en_o = en;
    assign sdata_o   = en & sdata_in;

    AST_ERR_FORCES_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> (nonaudio_o && stat_o)); // R7
    AST_SDATA_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !sdata_o); // R11
endmodule

// File: tb/test_chst_flag_unit.sv
module test_chst_flag_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_err = 1'b0;
    logic       pll_lock = 1'b0;
    logic       pre_stb = 1'b0;
    logic [1:0] pre_kind = 2'd3;
    logic       cs_nonaudio = 1'b0;
    logic       cs_emph = 1'b0;
    logic [1:0] cmp_flags = 2'b00;
    logic       or_sel = 1'b0;
    logic       stat_sel = 1'b1;
    logic       lrck = 1'b0;
    logic       sdata_in = 1'b0;
    logic       nonaudio_o, stat_o, data_en_o, sdata_o;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    chst_flag_unit i_chst_flag_unit (
        .clk(clk), .rst_n(rst_n), .rx_err(rx_err), .pll_lock(pll_lock),
        .pre_stb(pre_stb), .pre_kind(pre_kind), .cs_nonaudio(cs_nonaudio),
        .cs_emph(cs_emph), .cmp_flags(cmp_flags), .or_sel(or_sel),
        .stat_sel(stat_sel), .lrck(lrck), .sdata_in(sdata_in),
        .nonaudio_o(nonaudio_o), .stat_o(stat_o), .data_en_o(data_en_o),
        .sdata_o(sdata_o)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic strobe(input logic [1:0] kind);
        pre_kind = kind;
        pre_stb  = 1'b1;
        tick();
        pre_stb  = 1'b0;
        pre_kind = 2'd3;
    endtask

    task automatic t_reset;
        sdata_in = 1'b1;
        check(nonaudio_o, 1'b0, "R1 nonaudio after reset");
        check(stat_o, 1'b0, "R1 stat after reset");
        check(data_en_o, 1'b0, "R1 enable after reset");
        check(sdata_o, 1'b0, "R1 sdata after reset");
        sdata_in = 1'b0;
    endtask

    task automatic t_latch;
        cs_nonaudio = 1'b1; cs_emph = 1'b1;
        tick();
        check(nonaudio_o, 1'b0, "R3 no capture without block start");
        strobe(2'd1);
        check(nonaudio_o, 1'b0, "R3 kind 1 does not capture");
        strobe(2'd0);
        check(nonaudio_o, 1'b1, "R2 non-audio captured");
        check(stat_o, 1'b1, "R5 emphasis captured");
        cs_nonaudio = 1'b0; cs_emph = 1'b0;
        tick(2);
        check(nonaudio_o, 1'b1, "R3 held within block");
        check(stat_o, 1'b1, "R3 emphasis held within block");
        strobe(2'd0);
        check(nonaudio_o, 1'b0, "R2 PCM captured");
        check(stat_o, 1'b0, "R5 no emphasis captured");
    endtask

    task automatic t_or;
        cmp_flags = 2'b10; or_sel = 1'b0;
        tick();
        check(nonaudio_o, 1'b0, "R4 flags ignored with OR off");
        or_sel = 1'b1;
        tick();
        check(nonaudio_o, 1'b1, "R4 flag ORed in");
        cmp_flags = 2'b00;
        tick();
        check(nonaudio_o, 1'b0, "R4 no flag with OR on");
        or_sel = 1'b0;
    endtask

    task automatic t_stat;
        stat_sel = 1'b0; pll_lock = 1'b0;
        tick();
        check(stat_o, 1'b1, "R6 unlock shown");
        pll_lock = 1'b1;
        tick();
        check(stat_o, 1'b0, "R6 lock shown");
        stat_sel = 1'b1;
    endtask

    task automatic t_err;
        rx_err = 1'b1;
        #1;
        check(nonaudio_o, 1'b1, "R7 nonaudio forced same cycle");
        check(stat_o, 1'b1, "R7 stat forced same cycle");
        cs_nonaudio = 1'b1;
        strobe(2'd0);
        rx_err = 1'b0;
        cs_nonaudio = 1'b0;
        tick();
        check(nonaudio_o, 1'b0, "R12 block start ignored during error");
    endtask

    task automatic t_enable;
        pll_lock = 1'b1;
        strobe(2'd0);
        strobe(2'd1);
        strobe(2'd3);
        lrck = ~lrck;
        tick(3);
        check(data_en_o, 1'b0, "R8 missing kind 2 keeps output off");
        strobe(2'd2);
        tick();
        check(data_en_o, 1'b0, "R9 no enable without LR transition");
        lrck = ~lrck;
        tick();
        check(data_en_o, 1'b0, "R9 not yet after one edge");
        tick();
        check(data_en_o, 1'b1, "R9 enabled after second edge");
        sdata_in = 1'b1;
        #1;
        check(sdata_o, 1'b1, "R11 data passes");
        sdata_in = 1'b0;
        #1;
        check(sdata_o, 1'b0, "R11 data follows low");
    endtask

    task automatic t_drop;
        rx_err = 1'b1; sdata_in = 1'b1;
        tick();
        check(data_en_o, 1'b0, "R10 error clears enable");
        check(sdata_o, 1'b0, "R11 data muted when disabled");
        rx_err = 1'b0;
        tick(3);
        check(data_en_o, 1'b0, "R10 no restart without LR transition");
        lrck = ~lrck;
        tick(2);
        check(data_en_o, 1'b1, "R10 restart after LR transition");
        pll_lock = 1'b0;
        tick();
        check(data_en_o, 1'b0, "R10 lock loss clears enable");
        pll_lock = 1'b1;
        tick();
        lrck = ~lrck;
        tick(3);
        check(data_en_o, 1'b0, "R8 lock loss erased preamble record");
        sdata_in = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_latch();
        t_or();
        t_stat();
        t_err();
        t_enable();
        t_drop();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule